// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small bank of one-bit semaphores shared by two ports, called A and B. Either port claims a semaphore by writing 0 to it, gives it up or cancels a waiting claim by writing 1, and tests it by reading. A read returns 0 only to the port that currently holds the semaphore. A claim that arrives while the other port holds the semaphore is remembered. Ownership then passes to the waiting port on the same clock edge that the holder writes its release, so software only has to poll until it reads 0.

Each port has a select input for semaphore space and an enable input for the neighbouring memory array. The block decodes the two and passes a qualified memory enable on to the array. The array itself is not part of this block. All state changes on one clock. Read data is registered and presents the one-bit result on every bit of the read bus. A synchronous reset frees every semaphore so that simulation starts from a known state. In hardware, software is expected to free each semaphore by writing 1 from both ports.

Top module: `sem_unit`

## Requirements
- R1: A semaphore access happens in a cycle where the port's semaphore select is 1 and its memory enable is 0. A write in such a cycle with data bit 0 to a free semaphore makes that port the holder from the next clock edge. A holder that writes 0 again keeps the semaphore.
- R2: When the holder writes 1, it releases the semaphore. If no claim is waiting, the semaphore is free and reads 1 from both ports.
- R3: A read access, meaning a semaphore access with write at 0, loads the read bus on the next clock edge. Every bit of the bus is 0 if the reading port holds the addressed semaphore and 1 otherwise, using the state as it stood before that edge. In cycles without a read access, the read bus keeps its value.
- R4: A port that writes 0 while the other port holds the semaphore keeps reading 1. It becomes the holder on the edge where the holder writes 1.
- R5: A waiting port that writes 1 cancels its claim. A later release by the holder then leaves the semaphore free.
- R6: If both ports write 0 in the same cycle to a free semaphore, port A becomes the holder and port B's claim waits.
- R7: At no time can both ports read 0 from the same semaphore.
- R8: The address selects one of eight independent semaphores. A write to one semaphore leaves all the others unchanged.
- R9: If the semaphore select and the memory enable are both 1, the cycle is ignored: no semaphore changes, the read bus holds, and the memory enable output is 0. In all other cycles the memory enable output equals the memory enable input when the semaphore select is 0, and is 0 otherwise. This output is combinational.
- R10: After reset, all semaphores are free and both read buses read all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_sem_sel | input | 1 | Port A semaphore space select |
| a_mem_en | input | 1 | Port A memory enable |
| a_wr | input | 1 | Port A write strobe (0 means read) |
| a_addr | input | 3 | Port A semaphore number |
| a_wbit | input | 1 | Port A write data bit |
| a_rdata | output | 16 | Port A registered read data |
| a_mem_go | output | 1 | Port A qualified memory enable |
| b_sem_sel | input | 1 | Port B semaphore space select |
| b_mem_en | input | 1 | Port B memory enable |
| b_wr | input | 1 | Port B write strobe (0 means read) |
| b_addr | input | 3 | Port B semaphore number |
| b_wbit | input | 1 | Port B write data bit |
| b_rdata | output | 16 | Port B registered read data |
| b_mem_go | output | 1 | Port B qualified memory enable |

## Verification
A directed procurement sequence alternates claims and releases between the ports and reads both ports after every step. This separates a free semaphore from one held by the other port, and a waiting claim from a cancelled one. Same-cycle claims on a free semaphore show whether the priority to port A and the waiting claim for port B are both right. Writes to one semaphore followed by reads of its neighbours expose address decoding faults. Cycles with both select and enable active show whether a conflicting access leaks into the state. A long stretch of seeded random traffic mixes reads, claims, releases, memory cycles and conflicting cycles on both ports at once. It compares every read and every memory enable against a reference model built from the rules above, and checks that the two ports never both read 0 from the same semaphore.

// File: rtl/sem_pkg.sv
package sem_pkg;
  // Per-semaphore state: a claim bit per port and which port the holder is.
  typedef struct packed {
    logic req_a;
    logic req_b;
    logic own_b;
  } sem_state_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sem_sel,
  input  logic               mem_en,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  output logic               mem_go,
  output logic [NUM_SEM-1:0] wr_hit,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr
);
  logic sem_acc;

  assign sem_acc = sem_sel & ~mem_en;
  assign mem_go  = mem_en & ~sem_sel;
  assign rd_en   = sem_acc & ~wr;
  assign rd_addr = addr;

  for (genvar s = 0; s < NUM_SEM; s++) begin : g_hit
    assign wr_hit[s] = sem_acc & wr & (addr == ADDR_W'(s));
  end

  // R9: a conflicting select reaches neither space
  a_r9_conflict_blocked: assert property (@(posedge clk) disable iff (rst)
    (sem_sel && mem_en) |-> (!mem_go && wr_hit == '0 && !rd_en));
  // R8: at most one semaphore written per port per cycle
  a_r8_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit));
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_wr,
  input  logic a_wbit,
  input  logic b_wr,
  input  logic b_wbit,
  output logic a_owns,
  output logic b_owns
);
  sem_state_t st, st_nx;
  logic nreq_a, nreq_b, held, keep;

  always_comb begin
    nreq_a = a_wr ? ~a_wbit : st.req_a;
    nreq_b = b_wr ? ~b_wbit : st.req_b;
    held   = st.own_b ? st.req_b : st.req_a;
    keep   = held & (st.own_b ? nreq_b : nreq_a);
    st_nx.req_a = nreq_a;
    st_nx.req_b = nreq_b;
    if (keep)        st_nx.own_b = st.own_b;
    else if (nreq_a) st_nx.own_b = 1'b0;
    else if (nreq_b) st_nx.own_b = 1'b1;
    else             st_nx.own_b = st.own_b;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= st_nx;
  end

  assign a_owns = st.req_a & ~st.own_b;
  assign b_owns = st.req_b &  st.own_b;

  // R7: any live claim implies the holder is one of the claimants
  a_r7_holder_claims: assert property (@(posedge clk) disable iff (rst)
    (st.req_a || st.req_b) |-> (st.own_b ? st.req_b : st.req_a));
  // R1: claim on free semaphore is granted next edge
  a_r1_free_claim: assert property (@(posedge clk) disable iff (rst)
    (!st.req_a && !st.req_b && a_wr && !a_wbit && !b_wr) |=> a_owns);
  // R2: a release by A removes its hold
  a_r2_release: assert property (@(posedge clk) disable iff (rst)
    (a_wr && a_wbit) |=> !a_owns);
  // R4: waiting B takes over when A releases
  a_r4_handoff: assert property (@(posedge clk) disable iff (rst)
    (a_owns && st.req_b && a_wr && a_wbit && !b_wr) |=> b_owns);
  // R5: a cancelled claim leaves nothing behind
  a_r5_withdraw: assert property (@(posedge clk) disable iff (rst)
    (a_owns && st.req_b && b_wr && b_wbit && !a_wr) |=> (a_owns && !st.req_b));
  // R6: same-cycle claims on a free semaphore favour port A
  a_r6_tie_left: assert property (@(posedge clk) disable iff (rst)
    (!st.req_a && !st.req_b && a_wr && !a_wbit && b_wr && !b_wbit)
    |=> (a_owns && st.req_b));
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = $clog2(NUM_SEM),
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [NUM_SEM-1:0] owns,
  output logic [DATA_W-1:0]  rdata
);
  always_ff @(posedge clk) begin
    if (rst)        rdata <= '1;
    else if (rd_en) rdata <= {DATA_W{~owns[rd_addr]}};
  end

  // R3: all bits carry the same value
  a_r3_replicated: assert property (@(posedge clk) disable iff (rst)
    (rdata == '0) || (rdata == '1));
  // R3: read bus holds without a read access
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/sem_unit.sv
module sem_unit #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = $clog2(NUM_SEM),
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_sem_sel,
  input  logic              a_mem_en,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wbit,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_mem_go,
  input  logic              b_sem_sel,
  input  logic              b_mem_en,
  input  logic              b_wr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wbit,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_mem_go
);
  logic [NUM_SEM-1:0] a_hit, b_hit, a_own, b_own;
  logic               a_rd, b_rd;
  logic [ADDR_W-1:0]  a_raddr, b_raddr;

  sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_dec_a (
    .clk(clk), .rst(rst), .sem_sel(a_sem_sel), .mem_en(a_mem_en), .wr(a_wr),
    .addr(a_addr), .mem_go(a_mem_go), .wr_hit(a_hit), .rd_en(a_rd),
    .rd_addr(a_raddr));

  sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_dec_b (
    .clk(clk), .rst(rst), .sem_sel(b_sem_sel), .mem_en(b_mem_en), .wr(b_wr),
    .addr(b_addr), .mem_go(b_mem_go), .wr_hit(b_hit), .rd_en(b_rd),
    .rd_addr(b_raddr));

  for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
    sem_cell u_cell (
      .clk(clk), .rst(rst),
      .a_wr(a_hit[s]), .a_wbit(a_wbit),
      .b_wr(b_hit[s]), .b_wbit(b_wbit),
      .a_owns(a_own[s]), .b_owns(b_own[s]));
  end

  sem_read_port #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_a (
    .clk(clk), .rst(rst), .rd_en(a_rd), .rd_addr(a_raddr), .owns(a_own),
    .rdata(a_rdata));

  sem_read_port #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_b (
    .clk(clk), .rst(rst), .rd_en(b_rd), .rd_addr(b_raddr), .owns(b_own),
    .rdata(b_rdata));

  // R7: no semaphore held by both ports
  a_r7_mutex: assert property (@(posedge clk) disable iff (rst)
    (a_own & b_own) == '0);
  // R7: both ports reading the same semaphore never both see 0
  a_r7_read_mutex: assert property (@(posedge clk) disable iff (rst)
    (a_rd && b_rd && a_raddr == b_raddr) |=> !(a_rdata == '0 && b_rdata == '0));
endmodule

// File: tb/tb_sem_unit.sv
`timescale 1ns/1ps
module tb_sem_unit;
  localparam int OP_IDLE = 0, OP_RD = 1, OP_W0 = 2, OP_W1 = 3, OP_BAD = 4, OP_MEM = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_sem_sel = 0, a_mem_en = 0, a_wr = 0, a_wbit = 0;
  logic b_sem_sel = 0, b_mem_en = 0, b_wr = 0, b_wbit = 0;
  logic [2:0] a_addr = '0, b_addr = '0;
  logic [15:0] a_rdata, b_rdata;
  logic a_mem_go, b_mem_go;

  int n_cmp = 0, n_bad = 0;
  bit mreq_a [8], mreq_b [8], mown_b [8];
  logic [15:0] exp_ra = '1, exp_rb = '1;

  always #2.5 clk = ~clk;

  sem_unit dut (
    .clk(clk), .rst(rst),
    .a_sem_sel(a_sem_sel), .a_mem_en(a_mem_en), .a_wr(a_wr), .a_addr(a_addr),
    .a_wbit(a_wbit), .a_rdata(a_rdata), .a_mem_go(a_mem_go),
    .b_sem_sel(b_sem_sel), .b_mem_en(b_mem_en), .b_wr(b_wr), .b_addr(b_addr),
    .b_wbit(b_wbit), .b_rdata(b_rdata), .b_mem_go(b_mem_go));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] rd_model(input bit is_b, input int s);
    bit holds = is_b ? (mreq_b[s] && mown_b[s]) : (mreq_a[s] && !mown_b[s]);
    return holds ? 16'h0000 : 16'hFFFF;
  endfunction

  // reference update from the claim/release/priority rules
  function automatic void model_step(input int opa, input int adda, input int opb, input int addb);
    for (int s = 0; s < 8; s++) begin
      bit nra = mreq_a[s], nrb = mreq_b[s], held, keep;
      if ((opa == OP_W0 || opa == OP_W1) && adda == s) nra = (opa == OP_W0);
      if ((opb == OP_W0 || opb == OP_W1) && addb == s) nrb = (opb == OP_W0);
      held = mown_b[s] ? mreq_b[s] : mreq_a[s];
      keep = held && (mown_b[s] ? nrb : nra);
      if (!keep) begin
        if (nra) mown_b[s] = 1'b0;
        else if (nrb) mown_b[s] = 1'b1;
      end
      mreq_a[s] = nra;
      mreq_b[s] = nrb;
    end
  endfunction

  task automatic drive(input bit is_b, input int op, input int addr);
    logic ss = (op >= OP_RD && op <= OP_BAD);
    logic me = (op == OP_BAD || op == OP_MEM);
    logic w  = (op == OP_W0 || op == OP_W1 || op == OP_BAD);
    logic wb = (op == OP_W1);
    if (!is_b) begin
      a_sem_sel = ss; a_mem_en = me; a_wr = w; a_wbit = wb; a_addr = 3'(addr);
    end else begin
      b_sem_sel = ss; b_mem_en = me; b_wr = w; b_wbit = wb; b_addr = 3'(addr);
    end
  endtask

  // one clock of traffic on both ports; called just after a falling edge
  task automatic cycle(input string req, input int opa, input int adda,
                       input int opb, input int addb);
    drive(1'b0, opa, adda);
    drive(1'b1, opb, addb);
    #0.5;
    chk("R9 mem_go A", {15'b0, a_mem_go}, {15'b0, opa == OP_MEM});
    chk("R9 mem_go B", {15'b0, b_mem_go}, {15'b0, opb == OP_MEM});
    if (opa == OP_RD) exp_ra = rd_model(1'b0, adda);
    if (opb == OP_RD) exp_rb = rd_model(1'b1, addb);
    @(posedge clk);
    model_step(opa, adda, opb, addb);
    @(negedge clk);
    chk({req, " A read"}, a_rdata, exp_ra);
    chk({req, " B read"}, b_rdata, exp_rb);
    if (opa == OP_RD && opb == OP_RD && adda == addb)
      chk("R7 both zero", {15'b0, (a_rdata == '0 && b_rdata == '0)}, 16'h0);
  endtask

  task automatic read_both(input string req, input int s, input logic [15:0] ea,
                           input logic [15:0] eb);
    cycle(req, OP_RD, s, OP_RD, s);
    chk({req, " A value"}, a_rdata, ea);
    chk({req, " B value"}, b_rdata, eb);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5E3A_0001));
    for (int s = 0; s < 8; s++) begin mreq_a[s] = 0; mreq_b[s] = 0; mown_b[s] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10 reset A", a_rdata, 16'hFFFF);
    chk("R10 reset B", b_rdata, 16'hFFFF);
    for (int s = 0; s < 8; s++) read_both("R10", s, 16'hFFFF, 16'hFFFF);

    // R1/R2/R4 procurement sequence on semaphore 2
    cycle("R1", OP_W0, 2, OP_IDLE, 0);
    read_both("R1", 2, 16'h0000, 16'hFFFF);
    cycle("R1", OP_W0, 2, OP_IDLE, 0);
    read_both("R1 rewrite", 2, 16'h0000, 16'hFFFF);
    cycle("R4", OP_IDLE, 0, OP_W0, 2);
    read_both("R4 waiting", 2, 16'h0000, 16'hFFFF);
    cycle("R4", OP_W1, 2, OP_IDLE, 0);
    read_both("R4 handoff", 2, 16'hFFFF, 16'h0000);
    cycle("R2", OP_IDLE, 0, OP_W1, 2);
    read_both("R2 free", 2, 16'hFFFF, 16'hFFFF);
    // R5 withdraw
    cycle("R5", OP_IDLE, 0, OP_W0, 2);
    cycle("R5", OP_W0, 2, OP_IDLE, 0);
    read_both("R5 b holds", 2, 16'hFFFF, 16'h0000);
    cycle("R5", OP_W1, 2, OP_IDLE, 0);
    cycle("R5", OP_IDLE, 0, OP_W1, 2);
    read_both("R5 free", 2, 16'hFFFF, 16'hFFFF);
    // R6 tie
    cycle("R6", OP_W0, 6, OP_W0, 6);
    read_both("R6 tie", 6, 16'h0000, 16'hFFFF);
    cycle("R6", OP_W1, 6, OP_IDLE, 0);
    read_both("R6 pending granted", 6, 16'hFFFF, 16'h0000);
    cycle("R6", OP_IDLE, 0, OP_W1, 6);
    // R8 independence
    cycle("R8", OP_W0, 3, OP_IDLE, 0);
    read_both("R8 target", 3, 16'h0000, 16'hFFFF);
    read_both("R8 neighbour lo", 2, 16'hFFFF, 16'hFFFF);
    read_both("R8 neighbour hi", 4, 16'hFFFF, 16'hFFFF);
    cycle("R8", OP_W1, 3, OP_IDLE, 0);
    // R9 conflicting select ignored
    cycle("R9", OP_BAD, 5, OP_BAD, 5);
    read_both("R9 no claim", 5, 16'hFFFF, 16'hFFFF);
    cycle("R9", OP_RD, 5, OP_MEM, 1);
    chk("R9 hold B", b_rdata, 16'hFFFF);

    // R7 random traffic
    for (int i = 0; i < 3000; i++) begin
      int opa = int'($urandom_range(0, 5));
      int opb = int'($urandom_range(0, 5));
      int adda = int'($urandom_range(0, 7));
      int addb = ($urandom_range(0, 1) == 0) ? adda : int'($urandom_range(0, 7));
      cycle("R7 random", opa, adda, opb, addb);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule